// File: doc/BRIEF.md
# Fixed Off-Time Chopper Controller

This block regulates the current in one full bridge of a stepper-motor driver. It turns on one diagonal of the bridge, with the diagonal chosen by the winding polarity from the indexer. The drive stays on until an external sense comparator reports that the winding current has reached its trip level. A trip ends the on phase and starts an off phase whose length is fixed in clock cycles. During the off phase the winding current decays in one of two ways. In slow decay both low-side switches conduct. Mixed decay first drives the opposite diagonal for 5/16 of the off phase (fast decay) and then switches to slow decay for the rest.

Switching transients are masked by a blanking window: the comparator is not looked at for a set number of cycles after each on phase begins. Each half-bridge (leg) has its own dead-time inserter, so the high-side and low-side gate enables of a leg are never on together and are separated by a fixed gap. In the off phase, a zero-current indication turns every recirculation switch off, so the winding current cannot reverse. A disable input forces all four gate enables low, while the on/off timing keeps running underneath.

Top module: `chop_ctrl`

## Requirements
- R1: In the on phase with `polarity`=1, leg A drives high and leg B drives low (`gate_a_hi`, `gate_b_lo`). With `polarity`=0, leg A drives low and leg B drives high (`gate_a_lo`, `gate_b_hi`).
- R2: In the on phase, once blanking has ended, a cycle with `cmp_trip` high starts an off phase of exactly the off length in cycles, after which the on phase resumes. With leg A driving high, `gate_a_hi` is then low for off length + DEAD_CYC cycles.
- R3: The off length is `OFF_DEFAULT` when `off_sel`=0 and `off_prog` when `off_sel`=1. It is sampled at the trip, and a value of 0 is treated as 1.
- R4: With `decay_mixed`=0 at the trip, the off phase turns on both low-side enables and no high-side enable.
- R5: With `decay_mixed`=1 at the trip, the first floor(5·off/16) cycles of the off phase drive the diagonal opposite to the one that was driving, and the rest is slow decay. Polarity is sampled at the trip.
- R6: After reset and after every return to the on phase, `cmp_trip` is ignored for `BLANK_CYC` cycles.
- R7: The two enables of one leg are never high together. When one of them falls and the other is requested, both stay low for exactly `DEAD_CYC` cycles.
- R8: While `zero_cross` is high in the off phase, all four enables are low from the next cycle on.
- R9: `out_disable`=1 forces all four enables low from the next cycle on. The phase and counters keep running, so on release the outputs show whichever phase is current.
- R10: While `rst_n` is low, all enables are low. After reset the block starts in the on phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all times are counted in its cycles |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_trip | input | 1 | Sense comparator: current has reached the trip level |
| decay_mixed | input | 1 | Decay choice from the indexer: 1 mixed, 0 slow |
| polarity | input | 1 | Winding polarity from the indexer: 1 leg A high |
| zero_cross | input | 1 | Winding current is near zero |
| out_disable | input | 1 | 1 forces all gate enables off |
| off_sel | input | 1 | 0 default off length, 1 programmed off length |
| off_prog | input | OFF_W | Programmed off length in cycles |
| gate_a_hi | output | 1 | Leg A high-side enable |
| gate_a_lo | output | 1 | Leg A low-side enable |
| gate_b_hi | output | 1 | Leg B high-side enable |
| gate_b_lo | output | 1 | Leg B low-side enable |

## Verification
The bench applies comparator trips in slow decay and in mixed decay, with the default off length, with a programmed one, and with a programmed zero. For each trip it counts, over a window, the cycles each gate spends high or low. These counts separate the off length, the 5/16 fast slice and the dead gap, so an off-by-one in any one of them shows up on its own. A two-cycle trip pulse placed inside the blanking window, followed by a one-cycle pulse after it, shows that the window both masks the comparator and ends on time. The zero-current and disable patterns are applied in the middle of an off phase. The gate pattern seen after release then shows whether the timing carried on underneath or was restarted.

// File: rtl/chop_pkg.sv
package chop_pkg;

    // Request for one half-bridge leg
    typedef enum logic [1:0] {
        LEG_FLOAT = 2'd0,
        LEG_HI    = 2'd1,
        LEG_LO    = 2'd2
    } leg_cmd_e;

    typedef enum logic {
        PH_ON  = 1'b0,
        PH_OFF = 1'b1
    } phase_e;

    localparam int NUM_LEGS = 2;

endpackage

// File: rtl/chop_offtimer.sv
module chop_offtimer
    import chop_pkg::*;
#(
    parameter int OFF_W       = 16,
    parameter int OFF_DEFAULT = 3000,
    parameter int BLANK_CYC   = 100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmp_trip,
    input  logic             decay_mixed,
    input  logic             polarity,
    input  logic             off_sel,
    input  logic [OFF_W-1:0] off_prog,
    output phase_e           phase,
    output logic             fast_on,
    output logic             pol_hold
);

    localparam int BLANK_W = $clog2(BLANK_CYC + 2);

    typedef struct packed {
        phase_e             phase;
        logic [OFF_W-1:0]   off_cnt;
        logic [OFF_W-1:0]   fast_cnt;
        logic [BLANK_W-1:0] blank_cnt;
        logic               pol;
    } tim_s;

    tim_s s_d, s_q;
    logic [OFF_W-1:0] off_len;
    logic [OFF_W-1:0] fast_len;

    always_comb begin
        off_len = off_sel ? off_prog : OFF_W'(OFF_DEFAULT);
        if (off_len == '0) begin
            off_len = OFF_W'(1);
        end
        fast_len = OFF_W'(({3'b000, off_len} * (OFF_W + 3)'(5)) >> 4);

        s_d = s_q;
        case (s_q.phase)
            PH_ON: begin
                if (s_q.blank_cnt != '0) begin
                    s_d.blank_cnt = s_q.blank_cnt - 1'b1;
                end else if (cmp_trip) begin
                    s_d.phase    = PH_OFF;
                    s_d.off_cnt  = off_len - 1'b1;
                    s_d.fast_cnt = decay_mixed ? fast_len : '0;
                    s_d.pol      = polarity;
                end
            end
            default: begin
                if (s_q.fast_cnt != '0) begin
                    s_d.fast_cnt = s_q.fast_cnt - 1'b1;
                end
                if (s_q.off_cnt == '0) begin
                    s_d.phase     = PH_ON;
                    s_d.fast_cnt  = '0;
                    s_d.blank_cnt = BLANK_W'(BLANK_CYC);
                end else begin
                    s_d.off_cnt = s_q.off_cnt - 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.phase     <= PH_ON;
            s_q.off_cnt   <= '0;
            s_q.fast_cnt  <= '0;
            s_q.blank_cnt <= BLANK_W'(BLANK_CYC);
            s_q.pol       <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign phase    = s_q.phase;
    assign fast_on  = (s_q.phase == PH_OFF) && (s_q.fast_cnt != '0);
    assign pol_hold = s_q.pol;

    // R6
    blank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase == PH_ON && s_q.blank_cnt != '0) |=> (s_q.phase == PH_ON));

    // R2
    off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase == PH_OFF && s_q.off_cnt != '0) |=> (s_q.phase == PH_OFF));

    // R2
    off_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase == PH_OFF && s_q.off_cnt == '0) |=> (s_q.phase == PH_ON));

    // R5
    fast_inside_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fast_on) |-> (s_q.phase == PH_OFF || $past(s_q.off_cnt) == '0));

endmodule

// File: rtl/chop_steer.sv
module chop_steer
    import chop_pkg::*;
(
    input  phase_e   phase,
    input  logic     fast_on,
    input  logic     pol_hold,
    input  logic     polarity,
    input  logic     zero_cross,
    input  logic     out_disable,
    output leg_cmd_e cmd_a,
    output leg_cmd_e cmd_b
);

    always_comb begin
        cmd_a = LEG_FLOAT;
        cmd_b = LEG_FLOAT;
        if (out_disable) begin
            cmd_a = LEG_FLOAT;
            cmd_b = LEG_FLOAT;
        end else if (phase == PH_ON) begin
            cmd_a = polarity ? LEG_HI : LEG_LO;
            cmd_b = polarity ? LEG_LO : LEG_HI;
        end else if (zero_cross) begin
            cmd_a = LEG_FLOAT;
            cmd_b = LEG_FLOAT;
        end else if (fast_on) begin
            cmd_a = pol_hold ? LEG_LO : LEG_HI;
            cmd_b = pol_hold ? LEG_HI : LEG_LO;
        end else begin
            cmd_a = LEG_LO;
            cmd_b = LEG_LO;
        end
    end

endmodule

// File: rtl/chop_leg.sv
module chop_leg
    import chop_pkg::*;
#(
    parameter int DEAD_CYC = 48
) (
    input  logic     clk,
    input  logic     rst_n,
    input  leg_cmd_e cmd,
    output logic     hi,
    output logic     lo
);

    localparam int DEAD_W = $clog2(DEAD_CYC + 2);

    typedef struct packed {
        logic              hi;
        logic              lo;
        logic [DEAD_W-1:0] dcnt;
    } leg_s;

    leg_s s_d, s_q;
    logic want_hi, want_lo;

    always_comb begin
        want_hi = (cmd == LEG_HI);
        want_lo = (cmd == LEG_LO);
        s_d.hi  = want_hi && (s_q.hi || (s_q.dcnt == '0 && !s_q.lo));
        s_d.lo  = want_lo && (s_q.lo || (s_q.dcnt == '0 && !s_q.hi));
        if ((s_q.hi && !s_d.hi) || (s_q.lo && !s_d.lo)) begin
            s_d.dcnt = DEAD_W'(DEAD_CYC - 1);
        end else if (s_q.dcnt != '0) begin
            s_d.dcnt = s_q.dcnt - 1'b1;
        end else begin
            s_d.dcnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign hi = s_q.hi;
    assign lo = s_q.lo;

    initial begin
        // R7
        dead_param_chk: assert (DEAD_CYC >= 1);
    end

    // R7
    no_shoot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(s_q.hi && s_q.lo));

    // R7
    dead_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(s_q.lo) |-> !$past(s_q.hi)) and ($rose(s_q.hi) |-> !$past(s_q.lo)));

endmodule

// File: rtl/chop_ctrl.sv
module chop_ctrl
    import chop_pkg::*;
#(
    parameter int OFF_W       = 16,
    parameter int OFF_DEFAULT = 3000,
    parameter int BLANK_CYC   = 100,
    parameter int DEAD_CYC    = 48
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmp_trip,
    input  logic             decay_mixed,
    input  logic             polarity,
    input  logic             zero_cross,
    input  logic             out_disable,
    input  logic             off_sel,
    input  logic [OFF_W-1:0] off_prog,
    output logic             gate_a_hi,
    output logic             gate_a_lo,
    output logic             gate_b_hi,
    output logic             gate_b_lo
);

    phase_e   phase;
    logic     fast_on;
    logic     pol_hold;
    leg_cmd_e cmd_a, cmd_b;
    leg_cmd_e leg_cmd [NUM_LEGS];
    logic     leg_hi  [NUM_LEGS];
    logic     leg_lo  [NUM_LEGS];

    chop_offtimer #(
        .OFF_W      (OFF_W),
        .OFF_DEFAULT(OFF_DEFAULT),
        .BLANK_CYC  (BLANK_CYC)
    ) i_offtimer (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmp_trip   (cmp_trip),
        .decay_mixed(decay_mixed),
        .polarity   (polarity),
        .off_sel    (off_sel),
        .off_prog   (off_prog),
        .phase      (phase),
        .fast_on    (fast_on),
        .pol_hold   (pol_hold)
    );

    chop_steer i_steer (
        .phase      (phase),
        .fast_on    (fast_on),
        .pol_hold   (pol_hold),
        .polarity   (polarity),
        .zero_cross (zero_cross),
        .out_disable(out_disable),
        .cmd_a      (cmd_a),
        .cmd_b      (cmd_b)
    );

    assign leg_cmd[0] = cmd_a;
    assign leg_cmd[1] = cmd_b;

    for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
        chop_leg #(
            .DEAD_CYC(DEAD_CYC)
        ) i_leg (
            .clk  (clk),
            .rst_n(rst_n),
            .cmd  (leg_cmd[g]),
            .hi   (leg_hi[g]),
            .lo   (leg_lo[g])
        );
    end

    assign gate_a_hi = leg_hi[0];
    assign gate_a_lo = leg_lo[0];
    assign gate_b_hi = leg_hi[1];
    assign gate_b_lo = leg_lo[1];

    // R9
    disable_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_disable |=> !(gate_a_hi || gate_a_lo || gate_b_hi || gate_b_lo));

    // R8
    zero_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_OFF && zero_cross) |=> !(gate_a_hi || gate_a_lo || gate_b_hi || gate_b_lo));

    // R4
    slow_no_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_OFF && !fast_on) |=> !(gate_a_hi || gate_b_hi) || $past(phase) == PH_ON || $past(fast_on));

endmodule

// File: tb/test_chop_ctrl.sv
module test_chop_ctrl;
    import chop_pkg::*;

    localparam int OFF_W  = 8;
    localparam int OFF_D  = 40;
    localparam int BLANK  = 6;
    localparam int DEAD   = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmp_trip = 1'b0, decay_mixed = 1'b0, polarity = 1'b1;
    logic zero_cross = 1'b0, out_disable = 1'b0, off_sel = 1'b0;
    logic [OFF_W-1:0] off_prog = '0;
    logic gate_a_hi, gate_a_lo, gate_b_hi, gate_b_lo;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    chop_ctrl #(
        .OFF_W(OFF_W), .OFF_DEFAULT(OFF_D), .BLANK_CYC(BLANK), .DEAD_CYC(DEAD)
    ) i_chop_ctrl (
        .clk(clk), .rst_n(rst_n), .cmp_trip(cmp_trip), .decay_mixed(decay_mixed),
        .polarity(polarity), .zero_cross(zero_cross), .out_disable(out_disable),
        .off_sel(off_sel), .off_prog(off_prog),
        .gate_a_hi(gate_a_hi), .gate_a_lo(gate_a_lo),
        .gate_b_hi(gate_b_hi), .gate_b_lo(gate_b_lo)
    );

    function automatic int gates();
        return {28'd0, gate_a_hi, gate_a_lo, gate_b_hi, gate_b_lo};
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // sel: 0 a_hi low, 1 leg A both low, 2 any shoot-through,
    //      3 b_lo low, 4 b_hi high, 5 a_lo high
    task automatic count_win(input int n, input int sel, output int cnt);
        cnt = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            case (sel)
                0: cnt += int'(!gate_a_hi);
                1: cnt += int'(!gate_a_hi && !gate_a_lo);
                2: cnt += int'((gate_a_hi && gate_a_lo) || (gate_b_hi && gate_b_lo));
                3: cnt += int'(!gate_b_lo);
                4: cnt += int'(gate_b_hi);
                default: cnt += int'(gate_a_lo);
            endcase
        end
    endtask

    task automatic trip_once();
        @(negedge clk) cmp_trip = 1'b1;
        @(negedge clk) cmp_trip = 1'b0;
    endtask

    task automatic t_reset();
        wait_cyc(3);
        check("R10 gates off in reset", gates(), 0);
        @(negedge clk) rst_n = 1'b1;
        wait_cyc(4);
        // bits: a_hi a_lo b_hi b_lo
        check("R10/R1 on phase after reset pol=1", gates(), 4'b1001);
    endtask

    task automatic t_slow_default();
        int c;
        wait_cyc(BLANK + 4);
        trip_once();
        count_win(OFF_D + DEAD + 15, 0, c);
        check("R2/R3 a_hi low cycles, default off", c, OFF_D + DEAD);
        wait_cyc(BLANK + 4);
        trip_once();
        count_win(OFF_D + DEAD + 15, 1, c);
        check("R7 leg A dead gaps", c, 2 * DEAD);
        wait_cyc(BLANK + 4);
        trip_once();
        count_win(OFF_D + DEAD + 15, 3, c);
        check("R4 b_lo held through slow decay", c, 0);
        wait_cyc(BLANK + 4);
        trip_once();
        count_win(OFF_D + DEAD + 15, 5, c);
        check("R4 a_lo high in slow decay", c, OFF_D - DEAD);
    endtask

    task automatic t_blank();
        int c;
        wait_cyc(BLANK + 4);
        trip_once();
        wait_cyc(3);
        while (!gate_a_hi) @(negedge clk);
        cmp_trip = 1'b1;
        wait_cyc(2);
        cmp_trip = 1'b0;
        count_win(20, 0, c);
        check("R6 trip inside blanking ignored", c, 0);
        trip_once();
        wait_cyc(1);
        check("R6/R2 trip after blanking accepted", int'(gate_a_hi), 0);
        wait_cyc(OFF_D + DEAD + 10);
    endtask

    task automatic t_mixed();
        int c;
        decay_mixed = 1'b1;
        wait_cyc(BLANK + 4);
        trip_once();
        count_win(OFF_D + DEAD + 15, 4, c);
        check("R5 b_hi fast slice, off=40", c, (OFF_D * 5) / 16 - DEAD);
        wait_cyc(BLANK + 4);
        trip_once();
        count_win(OFF_D + DEAD + 15, 3, c);
        check("R5 b_lo low during fast slice", c, (OFF_D * 5) / 16 + DEAD);
        wait_cyc(BLANK + 4);
        trip_once();
        count_win(OFF_D + DEAD + 15, 2, c);
        check("R7 no shoot-through in mixed", c, 0);
        decay_mixed = 1'b0;
    endtask

    task automatic t_prog();
        int c;
        off_sel = 1'b1;
        off_prog = 8'd20;
        wait_cyc(BLANK + 4);
        trip_once();
        count_win(20 + DEAD + 15, 0, c);
        check("R3 programmed off 20", c, 20 + DEAD);
        decay_mixed = 1'b1;
        wait_cyc(BLANK + 4);
        trip_once();
        count_win(20 + DEAD + 15, 4, c);
        check("R5 fast slice, off=20", c, (20 * 5) / 16 - DEAD);
        decay_mixed = 1'b0;
        off_prog = 8'd0;
        wait_cyc(BLANK + 4);
        trip_once();
        // off length 1: a_lo never turns on, one dead gap only
        count_win(DEAD + 15, 0, c);
        check("R3 programmed zero acts as one", c, DEAD);
        off_sel = 1'b0;
        off_prog = '0;
    endtask

    task automatic t_pol0();
        polarity = 1'b0;
        wait_cyc(BLANK + 4);
        check("R1 on phase pol=0", gates(), 4'b0110);
        polarity = 1'b1;
        wait_cyc(BLANK + 4);
        check("R1 on phase back to pol=1", gates(), 4'b1001);
    endtask

    task automatic t_zero();
        trip_once();
        wait_cyc(10);
        check("R4 slow pattern before zero", gates(), 4'b0101);
        zero_cross = 1'b1;
        wait_cyc(2);
        check("R8 zero current turns all off", gates(), 0);
        zero_cross = 1'b0;
        wait_cyc(OFF_D + DEAD + 5);
        check("R8 on phase resumes", gates(), 4'b1001);
    endtask

    task automatic t_disable();
        wait_cyc(BLANK + 4);
        out_disable = 1'b1;
        wait_cyc(2);
        check("R9 disable in on phase", gates(), 0);
        out_disable = 1'b0;
        wait_cyc(BLANK + 4);
        trip_once();
        wait_cyc(4);
        out_disable = 1'b1;
        wait_cyc(2);
        check("R9 disable in off phase", gates(), 0);
        wait_cyc(8);
        out_disable = 1'b0;
        wait_cyc(8);
        check("R9 off phase kept across disable", gates(), 4'b0101);
        wait_cyc(OFF_D);
        check("R9 on phase after off ends", gates(), 4'b1001);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_slow_default();
        t_blank();
        t_mixed();
        t_prog();
        t_pol0();
        t_zero();
        t_disable();
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule